// File: doc/BRIEF.md
# Byte-wide double-buffered two-channel DAC loader

This block sits between an 8-bit host bus and two 12-bit converter channels. Each channel holds a 12-bit input stage and a separate 12-bit output register. The host fills an input stage one part at a time: the low eight bits in one write and the top four bits in another. Two address lines select the channel and the part. The write is framed by an active-low chip select and an active-low write strobe. The output registers never follow these writes directly. They change only when the host pulses an active-low load control, which commits both input stages at once. This lets the host set up both channels and then update them together.

All host pins are asynchronous to the block clock. They pass through a common synchronizer chain of `SYNC_STAGES` flops. A write is committed on the rising edge of the synchronized write strobe. The address, data and chip select used are the values seen in the last cycle the strobe was low. A load is recognized on the falling edge of the synchronized load control. Each channel raises a one-cycle update pulse when the load changes its output value.

Top module: `dac_loader`

## Requirements
- R1: Address decode for a committed write, with addr[1] selecting the channel (0 = A, 1 = B) and addr[0] selecting the part. When addr[0] = 0, data_in[7:0] goes to stage bits 7:0. When addr[0] = 1, data_in[3:0] goes to stage bits 11:8 and data_in[7:4] is ignored.
- R2: A write is committed only on a rising edge of the synchronized wr_n, and only when cs_n was low in the last cycle wr_n was low. A strobe with cs_n high leaves the input stages unchanged.
- R3: Writes to an input stage never change dac_a or dac_b.
- R4: A falling edge of the synchronized ldac_n copies both input stages into both output registers in the same clock cycle. The outputs change at no other time, apart from reset.
- R5: If a write commit and a load fall in the same cycle, the load transfers the input-stage contents from before that write. The write still lands in the input stage.
- R6: Synchronous active-high rst clears both input stages, both output registers and both update pulses to zero.
- R7: upd_a and upd_b each pulse high for exactly one cycle when a load changes that channel's output value. They stay low on a load that leaves the value unchanged.
- R8: After ldac_n falls at the pins, the outputs take the new values on the (SYNC_STAGES+1)-th rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 8 | Host data byte |
| addr | input | 2 | Channel (bit 1) and part (bit 0) select |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; commit on its rising edge |
| ldac_n | input | 1 | Active-low load control; transfer on its falling edge |
| dac_a | output | 12 | Channel A output register |
| dac_b | output | 12 | Channel B output register |
| upd_a | output | 1 | One-cycle pulse when dac_a changes on a load |
| upd_b | output | 1 | One-cycle pulse when dac_b changes on a load |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default 2. This moves every commit and load one cycle later and makes the latency check of R8 depend on the parameter rather than on a fixed count. With the longer chain, the bench can still line up a strobe rise and a load fall in the same synchronized cycle. That exercises the collision ordering, the ignored high data bits of a nibble write, and strobes with the chip select inactive. A behavioural model fed from the raw pins is compared with the outputs and pulses every cycle.

// File: rtl/dacl_pkg.sv
package dacl_pkg;

    localparam int BUS_W    = 8;
    localparam int DAC_W    = 12;
    localparam int HI_W     = DAC_W - BUS_W;
    localparam int CH_COUNT = 2;
    localparam int CH_SEL_W = $clog2(CH_COUNT);
    localparam int ADDR_W   = CH_SEL_W + 1;

    typedef enum logic {
        PART_LO = 1'b0,
        PART_HI = 1'b1
    } part_e;

    typedef struct packed {
        logic              cs_n;
        logic              wr_n;
        logic              ldac_n;
        logic [ADDR_W-1:0] addr;
        logic [BUS_W-1:0]  data;
    } host_pins_t;

    localparam host_pins_t PINS_IDLE = '{
        cs_n:   1'b1,
        wr_n:   1'b1,
        ldac_n: 1'b1,
        addr:   '0,
        data:   '0
    };

    typedef struct packed {
        logic                valid;
        logic [CH_SEL_W-1:0] ch;
        part_e               part;
        logic [BUS_W-1:0]    data;
    } wr_req_t;

    function automatic part_e addr_part(input logic [ADDR_W-1:0] a);
        return part_e'(a[0]);
    endfunction

    function automatic logic [CH_SEL_W-1:0] addr_chan(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:1];
    endfunction

    function automatic logic [DAC_W-1:0] merge_part(
        input logic [DAC_W-1:0] cur,
        input part_e            part,
        input logic [BUS_W-1:0] b
    );
        logic [DAC_W-1:0] r;
        r = cur;
        if (part == PART_LO) r[BUS_W-1:0]     = b;
        else                 r[DAC_W-1:BUS_W] = b[HI_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/dacl_sync.sv
module dacl_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/dacl_host_if.sv
module dacl_host_if
    import dacl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  host_pins_t pins,
    output wr_req_t    req,
    output logic       load_evt
);

    logic       wr_q;
    logic       ld_q;
    host_pins_t cap;
    logic       wr_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            ld_q <= 1'b1;
            cap  <= PINS_IDLE;
        end else begin
            wr_q <= pins.wr_n;
            ld_q <= pins.ldac_n;
            if (!pins.wr_n) cap <= pins;
        end
    end

    assign wr_rise = pins.wr_n & ~wr_q;

    always_comb begin
        req.valid = wr_rise & ~cap.cs_n;
        req.ch    = addr_chan(cap.addr);
        req.part  = addr_part(cap.addr);
        req.data  = cap.data;
    end

    assign load_evt = ~pins.ldac_n & ld_q;

endmodule

// File: rtl/dacl_channel.sv
module dacl_channel
    import dacl_pkg::*;
#(
    parameter int CH_ID = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          req,
    input  logic             load_evt,
    output logic [DAC_W-1:0] dac,
    output logic             upd
);

    logic [DAC_W-1:0] stage;
    logic             hit;

    assign hit = req.valid && (req.ch == CH_SEL_W'(CH_ID));

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            dac   <= '0;
            upd   <= 1'b0;
        end else begin
            if (hit) stage <= merge_part(stage, req.part, req.data);
            if (load_evt) begin
                dac <= stage;
                upd <= (stage != dac);
            end else begin
                upd <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dac_loader.sv
module dac_loader
    import dacl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  data_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ldac_n,
    output logic [DAC_W-1:0]  dac_a,
    output logic [DAC_W-1:0]  dac_b,
    output logic              upd_a,
    output logic              upd_b
);

    localparam int PINS_W = $bits(host_pins_t);

    host_pins_t             raw_pins;
    logic [PINS_W-1:0]      sync_bits;
    host_pins_t             sync_pins;
    wr_req_t                req;
    logic                   load_evt;
    logic [DAC_W-1:0]       dac_bus [CH_COUNT];
    logic [CH_COUNT-1:0]    upd_bus;

    always_comb begin
        raw_pins.cs_n   = cs_n;
        raw_pins.wr_n   = wr_n;
        raw_pins.ldac_n = ldac_n;
        raw_pins.addr   = addr;
        raw_pins.data   = data_in;
    end

    dacl_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_bits)
    );

    assign sync_pins = host_pins_t'(sync_bits);

    dacl_host_if u_host (
        .clk      (clk),
        .rst      (rst),
        .pins     (sync_pins),
        .req      (req),
        .load_evt (load_evt)
    );

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
        dacl_channel #(.CH_ID(g)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .req      (req),
            .load_evt (load_evt),
            .dac      (dac_bus[g]),
            .upd      (upd_bus[g])
        );
    end

    assign dac_a = dac_bus[0];
    assign dac_b = dac_bus[1];
    assign upd_a = upd_bus[0];
    assign upd_b = upd_bus[1];

endmodule

// File: rtl/dac_loader_chk.sv
module dac_loader_chk
    import dacl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [DAC_W-1:0] dac_a,
    input logic [DAC_W-1:0] dac_b,
    input logic             upd_a,
    input logic             upd_b,
    input logic             load_evt
);

    // R3
    out_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(load_evt) |-> $stable(dac_a));

    // R3
    out_b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(load_evt) |-> $stable(dac_b));

    // R7
    upd_a_change_chk: assert property (@(posedge clk) disable iff (rst)
        $past(load_evt) |-> (upd_a == (dac_a != $past(dac_a))));

    // R7
    upd_b_change_chk: assert property (@(posedge clk) disable iff (rst)
        $past(load_evt) |-> (upd_b == (dac_b != $past(dac_b))));

    // R7
    upd_a_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd_a |=> !upd_a);

    // R7
    upd_b_single_chk: assert property (@(posedge clk) disable iff (rst)
        upd_b |=> !upd_b);

    // R4
    upd_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_a || upd_b) |-> $past(load_evt));

    // R6
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_a == '0 && dac_b == '0 && !upd_a && !upd_b));

endmodule

bind dac_loader dac_loader_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .dac_a    (dac_a),
    .dac_b    (dac_b),
    .upd_a    (upd_a),
    .upd_b    (upd_b),
    .load_evt (load_evt)
);

// File: tb/dac_loader_tb.sv
`timescale 1ns/1ps
module dac_loader_tb;

    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  data_in = 8'h00;
    logic [1:0]  addr = 2'b00;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        ldac_n = 1'b1;
    logic [11:0] dac_a, dac_b;
    logic        upd_a, upd_b;

    int checks = 0;
    int bad = 0;
    int cnt_a = 0;
    int cnt_b = 0;
    bit model_ok = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dac_loader #(.SYNC_STAGES(S)) u_dut (
        .clk(clk), .rst(rst), .data_in(data_in), .addr(addr),
        .cs_n(cs_n), .wr_n(wr_n), .ldac_n(ldac_n),
        .dac_a(dac_a), .dac_b(dac_b), .upd_a(upd_a), .upd_b(upd_b)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference fed from the raw pins
    // bundle: [12]=cs_n [11]=wr_n [10]=ldac_n [9:8]=addr [7:0]=data
    logic [12:0] pipe[$];
    logic [11:0] m_in [2];
    logic [11:0] m_out[2];
    logic        m_upd[2];
    logic        m_wd, m_ld;
    logic [12:0] m_cap;

    always @(posedge clk) begin
        logic [12:0] cur;
        logic [11:0] nxt[2];
        logic rise, fall;
        if (rst) begin
            pipe = {};
            for (int i = 0; i < S; i++) pipe.push_front(13'h1C00);
            for (int c = 0; c < 2; c++) begin
                m_in[c] = 0; m_out[c] = 0; m_upd[c] = 0;
            end
            m_wd = 1; m_ld = 1; m_cap = 13'h1C00;
            model_ok = 1;
        end else begin
            cur  = pipe[S-1];
            rise = cur[11] && !m_wd;
            fall = !cur[10] && m_ld;
            nxt[0] = m_in[0]; nxt[1] = m_in[1];
            if (rise && !m_cap[12]) begin
                if (!m_cap[8]) nxt[m_cap[9]][7:0]  = m_cap[7:0];
                else           nxt[m_cap[9]][11:8] = m_cap[3:0];
            end
            for (int c = 0; c < 2; c++) begin
                if (fall) begin
                    m_upd[c] = (m_out[c] != m_in[c]);
                    m_out[c] = m_in[c];
                end else m_upd[c] = 0;
                m_in[c] = nxt[c];
            end
            if (!cur[11]) m_cap = cur;
            m_wd = cur[11];
            m_ld = cur[10];
            pipe.push_front({cs_n, wr_n, ldac_n, addr, data_in});
            void'(pipe.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst && model_ok && !done) begin
            check("R4 dac_a vs model", dac_a, m_out[0]);
            check("R4 dac_b vs model", dac_b, m_out[1]);
            check("R7 upd_a vs model", upd_a, m_upd[0]);
            check("R7 upd_b vs model", upd_b, m_upd[1]);
            cnt_a += upd_a;
            cnt_b += upd_b;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        addr = a; data_in = d; cs_n = sel_n;
        @(negedge clk); wr_n = 1'b0;
        idle(2);
        wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        idle(S + 2);
    endtask

    task automatic do_load();
        cnt_a = 0; cnt_b = 0;
        @(negedge clk); ldac_n = 1'b0;
        idle(2);
        ldac_n = 1'b1;
        idle(S + 3);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R6: reset state
        check("R6 dac_a reset", dac_a, 0);
        check("R6 dac_b reset", dac_b, 0);
        check("R6 upd reset", {upd_a, upd_b}, 0);

        bus_write(2'b00, 8'h5A, 1'b0);
        bus_write(2'b01, 8'hF3, 1'b0);
        bus_write(2'b10, 8'hC7, 1'b0);
        bus_write(2'b11, 8'h0E, 1'b0);
        // R3: outputs unchanged by stage writes
        check("R3 dac_a before load", dac_a, 0);
        check("R3 dac_b before load", dac_b, 0);

        // R8: latency of the transfer, then R1 and R4 values
        cnt_a = 0; cnt_b = 0;
        @(negedge clk); ldac_n = 1'b0;
        idle(S);
        check("R8 dac_a not yet", dac_a, 0);
        @(negedge clk);
        check("R8 dac_a updated", dac_a, 12'h35A);
        check("R1 dac_b value", dac_b, 12'hEC7);
        ldac_n = 1'b1;
        idle(S + 3);
        check("R7 upd_a count", cnt_a, 1);
        check("R7 upd_b count", cnt_b, 1);

        // R2: strobe without chip select has no effect
        bus_write(2'b00, 8'h11, 1'b1);
        do_load();
        check("R2 dac_a unchanged", dac_a, 12'h35A);
        check("R7 no pulse on same value A", cnt_a, 0);
        check("R7 no pulse on same value B", cnt_b, 0);

        // R5: write commit coinciding with a load
        bus_write(2'b10, 8'h00, 1'b0);
        @(negedge clk);
        addr = 2'b00; data_in = 8'h99; cs_n = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        idle(2);
        cnt_a = 0; cnt_b = 0;
        wr_n = 1'b1; ldac_n = 1'b0;
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); ldac_n = 1'b1;
        idle(S + 3);
        check("R5 dac_a old stage", dac_a, 12'h35A);
        check("R5 dac_b value", dac_b, 12'hE00);
        check("R5 upd_a count", cnt_a, 0);
        do_load();
        check("R5 write landed", dac_a, 12'h399);
        check("R7 upd_a after change", cnt_a, 1);

        // R6: mid-run reset clears stages too
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        check("R6 dac_a cleared", dac_a, 0);
        check("R6 dac_b cleared", dac_b, 0);
        do_load();
        check("R6 stage A cleared", dac_a, 0);
        check("R6 stage B cleared", dac_b, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule